// File: doc/BRIEF.md
# Scrambling NRZI Serializer for Video Words

This block turns 10-bit parallel video words into one serial bit stream for a coaxial link. Each word goes out one bit per serial-clock enable, least significant bit first. Ten serial cycles carry one word, and the next word follows with no gap. Every serial bit passes through a self-synchronising scrambler that divides by x^9 + x^4 + 1. It then passes through a differential (x + 1) stage that turns the NRZ stream into NRZI, so that the line carries transitions rather than levels. The block also gives out a word-rate pulse, which is the serial enable divided by ten. Upstream logic uses that pulse to present the next word, and it can also serve to monitor the serial rate.

The surrounding logic drives `ser_en` at the serial rate, for example 270 Mb/s for component video. It holds `word_in` and `word_vld` steady during each cycle in which `word_tick` is high. That is the cycle in which the word is taken. At the far end, a receiver that undoes the NRZI and then multiplies by the same polynomial recovers the words. Because the scrambler synchronises itself, the receiver needs no seed.

Top module: `vid_serial_scrambler`

## Requirements
- R1: A synchronous reset clears the scrambler register and the NRZI output to 0. It also sets the bit counter so that the first `ser_en` cycle after reset is a load cycle.
- R2: `word_tick` is high on every tenth `ser_en` cycle, beginning with the first one after reset, and it is never high while `ser_en` is low.
- R3: In a cycle with `word_tick` high and `word_vld` high, the block takes `word_in`. The ten `ser_en` cycles that follow serialise bits 0 to 9 of that word, in that order.
- R4: If `word_vld` is low in a load cycle, an all-zero word is sent in that word's slot.
- R5: Each serial bit b gives a scrambled bit s = b XOR r4 XOR r9. Here r4 and r9 are the scrambled bits from 4 and 9 `ser_en` cycles earlier, and r is 0 before reset ends.
- R6: After each `ser_en` cycle, `sdo` equals its previous value XOR the scrambled bit s.
- R7: While `ser_en` is low, `sdo` and the word position hold.
- R8: Bit 9 of a word and bit 0 of the next word go out on consecutive `ser_en` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Serial-bit enable, one pulse per line bit |
| word_in | input | 10 | Parallel word, taken when `word_tick` is high |
| word_vld | input | 1 | Word presented is real data; low sends zeros |
| word_tick | output | 1 | Word-rate pulse, serial enable divided by ten |
| sdo | output | 1 | Scrambled NRZI serial data |

## Verification
The bench sends every one of the 1024 word values back to back and recovers each one through an inverse NRZI stage and an inverse scrambler. A wrong tap, a missing feedback or an inverted NRZI relation would corrupt the recovered words, and bits sent MSB first would show up as bit-reversed words. A counter that inserts an idle cycle between words, or that begins the sweep off-phase, would move every later bit and make the `word_tick` phase check fail. A second pass spaces the `ser_en` pulses with idle cycles and sends a word with `word_vld` low. There, a design that moved on idle cycles would change `sdo`, and a design that latched stale data would recover a nonzero word.

// File: rtl/vid_serial_scrambler.sv
module vid_serial_scrambler #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_en,
  input  logic [W-1:0] word_in,
  input  logic         word_vld,
  output logic         word_tick,
  output logic         sdo
);
  localparam int CW = $clog2(W);
  localparam int SL = 9;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [SL-1:0] scr;
  logic          s_bit;

  assign word_tick = ser_en && (cnt == LAST);
  assign s_bit     = sh[0] ^ scr[3] ^ scr[SL-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= LAST;
      sh  <= '0;
      scr <= '0;
      sdo <= 1'b0;
    end else if (ser_en) begin
      scr <= {scr[SL-2:0], s_bit};
      sdo <= sdo ^ s_bit;
      if (cnt == LAST) begin
        cnt <= '0;
        sh  <= word_vld ? word_in : '0;
      end else begin
        cnt <= cnt + 1'b1;
        sh  <= sh >> 1;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sdo == 1'b0 && scr == '0 && cnt == LAST));

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    word_tick |=> (cnt == '0));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (word_tick && !word_vld) |=> (sh == '0));

  // R5
  scr_shift_chk: assert property (@(posedge clk) disable iff (rst)
    ser_en |=> (scr[SL-1:1] == $past(scr[SL-2:0])));

  // R6
  nrzi_chk: assert property (@(posedge clk) disable iff (rst)
    ser_en |=> ((sdo ^ $past(sdo)) == $past(s_bit)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_en |=> ($stable(sdo) && $stable(cnt)));
endmodule

// File: tb/vid_serial_scrambler_tb_top.sv
module vid_serial_scrambler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int MAXW = 1100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_en = 1'b0;
  logic word_vld = 1'b0;
  logic [W-1:0] word_in = '0;
  logic word_tick;
  logic sdo;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] wq [MAXW];
  bit           vq [MAXW];

  vid_serial_scrambler #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .ser_en(ser_en), .word_in(word_in),
    .word_vld(word_vld), .word_tick(word_tick), .sdo(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int nw, input int gap);
    logic [8:0] d;
    logic yprev, y, s, b, prev;
    logic [W-1:0] rx;
    logic [W-1:0] expw;
    @(negedge clk);
    rst = 1'b1; ser_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(sdo == 1'b0, "R1 sdo after reset", sdo, 0);
    chk(word_tick == 1'b0, "R2 no tick with ser_en low", word_tick, 0);
    d = '0; yprev = 1'b0; rx = '0;
    for (int n = 0; n <= 10*nw; n++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        ser_en = 1'b0;
        prev = sdo;
        #1 chk(word_tick == 1'b0, "R2 tick while ser_en low", word_tick, 0);
        @(posedge clk);
        #1 chk(sdo == prev, "R7 sdo held while idle", sdo, prev);
      end
      @(negedge clk);
      ser_en = 1'b1;
      if (n % 10 == 0) begin
        word_in  = (n/10 < nw) ? wq[n/10] : '0;
        word_vld = (n/10 < nw) ? vq[n/10] : 1'b0;
      end
      #1 chk(word_tick == (n % 10 == 0), "R2 tick phase", word_tick, (n % 10 == 0));
      @(posedge clk);
      #1;
      y = sdo;
      s = y ^ yprev;
      yprev = y;
      b = s ^ d[3] ^ d[8];
      d = {d[7:0], s};
      if (n >= 1) begin
        rx[(n-1) % 10] = b;
        if ((n-1) % 10 == 9) begin
          expw = vq[(n-1)/10] ? wq[(n-1)/10] : '0;
          if (vq[(n-1)/10])
            chk(rx == expw, "R3 R5 R6 R8 recovered word", rx, expw);
          else
            chk(rx == expw, "R4 invalid slot sends zero", rx, expw);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 1024; k++) begin wq[k] = W'(k); vq[k] = 1'b1; end
    for (int k = 1024; k < 1028; k++) begin wq[k] = W'(k * 37); vq[k] = (k % 2 == 0); end
    run(1028, 0);
    wq[0] = 10'h2A5; vq[0] = 1'b1;
    wq[1] = 10'h15A; vq[1] = 1'b1;
    wq[2] = 10'h3FF; vq[2] = 1'b0;
    wq[3] = 10'h001; vq[3] = 1'b1;
    wq[4] = 10'h200; vq[4] = 1'b1;
    wq[5] = 10'h3FF; vq[5] = 1'b1;
    run(6, 2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule